// File: doc/BRIEF.md
# Burst Write Slave Controller

This block is the control side of a memory-mapped slave that takes write bursts over the three write channels of an AXI4 port: address, data and response. It completes the VALID/READY handshake on each channel. It records the burst length and ID from the address phase, then counts the data beats against that length. It writes each beat into a small register store, one byte lane at a time, under the byte strobes. It raises the write response only after both the address handshake and the final data beat have completed.

The block accepts one transaction at a time. While a burst is in flight, or its response is waiting, the address channel is closed. The last-beat marker on the data channel is compared with the internal beat count. If the two disagree, the block pulses an error output, but the burst still runs to its full length. Cache, protection, lock and QoS attributes and the transfer size are accepted and have no effect. The response code is always OKAY. A combinational read port lets the surrounding logic see the contents of the store.

The reset input is active low. It may assert asynchronously and is released through a synchroniser inside the block.

Top module: `wrs_wr_slave`

## Requirements
- R1: While rst_n is low, aw_ready, w_ready, b_valid and proto_err are all low, and every byte of the store reads zero. Within SYNC_STAGES+1 clock cycles after rst_n rises, aw_ready is high.
- R2: aw_ready is high only while no transaction is open. It drops in the cycle after an address handshake and rises again in the cycle after the response handshake. It is never high together with w_ready or b_valid.
- R3: w_ready rises in the cycle after an address handshake and stays high until exactly aw_len+1 data handshakes have completed. w_ready is low at all other times.
- R4: A data handshake writes byte lane n of the addressed word from w_data[8n+7:8n] only when w_strb[n] is 1, and leaves lanes with a 0 strobe unchanged. A beat whose strobes are all zero still counts toward the burst length.
- R5: The first beat writes word index aw_addr[5:2], which is the byte address divided by DATA_W/8, modulo DEPTH. With aw_burst = 2'b00 (fixed), every beat writes that same word. With any other aw_burst code, each beat writes the next word, wrapping modulo DEPTH.
- R6: b_valid rises in the cycle after the final data handshake and never earlier. While b_valid is high, b_resp is 2'b00 and b_id equals the aw_id captured at the address handshake.
- R7: Once b_valid is high it stays high, with b_id and b_resp unchanged, until a cycle in which b_ready is high. It is low in the following cycle.
- R8: proto_err is high for exactly one cycle, the cycle after a data handshake in one of two cases: w_last is 1 on a beat other than beat aw_len, or w_last is 0 on beat aw_len. An early w_last does not shorten the burst.
- R9: aw_size, aw_lock, aw_cache, aw_prot and aw_qos have no effect on the handshakes, the stored data, b_id or b_resp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Transaction ID |
| aw_addr | input | ADDR_W | Byte start address |
| aw_len | input | LEN_W | Beats minus one |
| aw_size | input | 3 | Transfer size (ignored) |
| aw_burst | input | 2 | Burst type; 2'b00 is fixed |
| aw_lock | input | 1 | Lock attribute (ignored) |
| aw_cache | input | 4 | Cache attribute (ignored) |
| aw_prot | input | 3 | Protection attribute (ignored) |
| aw_qos | input | 4 | QoS attribute (ignored) |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Last-beat marker |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_id | output | ID_W | Response ID |
| b_resp | output | 2 | Response code, always OKAY |
| proto_err | output | 1 | One-cycle pulse on a last-beat mismatch |
| rd_idx | input | IDX_W | Store read word index |
| rd_data | output | DATA_W | Store word at rd_idx |

## Verification
All three ready/valid outputs are decoded from the phase register. A phase that is wrong inside the block therefore shows at the ports in the very next cycle: a ready or valid at the wrong time, or a response that arrives one beat early or late. A beat counter or word index that is off by one shows in two places. It moves the response or the error pulse by a cycle, and it leaves a byte in the wrong word, which the read port reveals as soon as the burst ends. The bench models the expected phase of every channel and compares it on each clock, then compares the whole store after each burst.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
   typedef enum logic [1:0] {
      WS_IDLE = 2'b00,
      WS_DATA = 2'b01,
      WS_RESP = 2'b10
   } wrs_phase_e;

   localparam logic [1:0] BURST_HOLD = 2'b00;
   localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/wrs_rst_sync.sv
module wrs_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_sync_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wrs_beat_ctl.sv
module wrs_beat_ctl
   import wrs_pkg::*;
#(
   parameter int LEN_W = 8,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             aw_fire,
   input  logic [IDX_W-1:0] aw_idx,
   input  logic [LEN_W-1:0] aw_len,
   input  logic             aw_hold,
   input  logic             w_fire,
   input  logic             w_last,
   input  logic             b_fire,
   output wrs_phase_e       phase,
   output logic [IDX_W-1:0] cur_idx,
   output logic             proto_err
);
   wrs_phase_e       phase_q;
   logic [LEN_W-1:0] cnt_q, len_q;
   logic [IDX_W-1:0] idx_q;
   logic             hold_q, err_q;
   logic             final_beat;

   assign final_beat = (cnt_q == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= WS_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         idx_q   <= '0;
         hold_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q <= w_fire && (w_last != final_beat);
         unique case (phase_q)
            WS_IDLE: if (aw_fire) begin
               phase_q <= WS_DATA;
               cnt_q   <= '0;
               len_q   <= aw_len;
               idx_q   <= aw_idx;
               hold_q  <= aw_hold;
            end
            WS_DATA: if (w_fire) begin
               if (final_beat) begin
                  phase_q <= WS_RESP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
                  if (!hold_q) idx_q <= idx_q + 1'b1;
               end
            end
            WS_RESP: if (b_fire) phase_q <= WS_IDLE;
            default: phase_q <= WS_IDLE;
         endcase
      end
   end

   assign phase     = phase_q;
   assign cur_idx   = idx_q;
   assign proto_err = err_q;
endmodule

// File: rtl/wrs_store.sv
module wrs_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W/8-1:0] wr_strb,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data
);
   localparam int LANES = DATA_W / 8;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [7:0] lane_mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) lane_mem[w] <= '0;
         end else if (we && wr_strb[ln]) begin
            lane_mem[wr_idx] <= wr_data[8*ln +: 8];
         end
      end

      assign rd_data[8*ln +: 8] = lane_mem[rd_idx];
   end
endmodule

// File: rtl/wrs_wr_slave.sv
module wrs_wr_slave
   import wrs_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int ID_W        = 4,
   parameter int LEN_W       = 8,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int STRB_W     = DATA_W / 8,
   localparam int OFF_W      = (STRB_W > 1) ? $clog2(STRB_W) : 0,
   localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [LEN_W-1:0]  aw_len,
   input  logic [2:0]        aw_size,
   input  logic [1:0]        aw_burst,
   input  logic              aw_lock,
   input  logic [3:0]        aw_cache,
   input  logic [2:0]        aw_prot,
   input  logic [3:0]        aw_qos,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic [STRB_W-1:0] w_strb,
   input  logic              w_last,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [ID_W-1:0]   b_id,
   output logic [1:0]        b_resp,
   output logic              proto_err,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 8 || DATA_W % 8 != 0 || (STRB_W & (STRB_W - 1)) != 0) begin : g_bad_data
      $error("wrs_wr_slave: DATA_W must be 8 times a power of two");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wrs_wr_slave: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < OFF_W + IDX_W) begin : g_bad_addr
      $error("wrs_wr_slave: ADDR_W too narrow for DEPTH words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wrs_wr_slave: SYNC_STAGES must be at least 2");
   end

   logic             rst_sync_n;
   wrs_phase_e       phase;
   logic [IDX_W-1:0] cur_idx;
   logic             aw_fire, w_fire, b_fire;
   logic [ID_W-1:0]  id_q;
   logic             unused_attrs;

   wrs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_sync_n(rst_sync_n)
   );

   assign aw_ready = rst_sync_n && (phase == WS_IDLE);
   assign w_ready  = (phase == WS_DATA);
   assign b_valid  = (phase == WS_RESP);
   assign aw_fire  = aw_valid && aw_ready;
   assign w_fire   = w_valid && w_ready;
   assign b_fire   = b_valid && b_ready;

   wrs_beat_ctl #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .aw_fire  (aw_fire),
      .aw_idx   (aw_addr[OFF_W +: IDX_W]),
      .aw_len   (aw_len),
      .aw_hold  (aw_burst == BURST_HOLD),
      .w_fire   (w_fire),
      .w_last   (w_last),
      .b_fire   (b_fire),
      .phase    (phase),
      .cur_idx  (cur_idx),
      .proto_err(proto_err)
   );

   wrs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .we     (w_fire),
      .wr_idx (cur_idx),
      .wr_data(w_data),
      .wr_strb(w_strb),
      .rd_idx (rd_idx),
      .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  id_q <= '0;
      else if (aw_fire) id_q <= aw_id;
   end

   assign b_id   = id_q;
   assign b_resp = RESP_OKAY;

   assign unused_attrs = ^{aw_size, aw_lock, aw_cache, aw_prot, aw_qos, aw_addr};
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk #(
   parameter int ID_W = 4
) (
   input logic            clk,
   input logic            rst_sync_n,
   input logic            aw_valid,
   input logic            aw_ready,
   input logic            w_valid,
   input logic            w_ready,
   input logic            b_valid,
   input logic            b_ready,
   input logic [ID_W-1:0] b_id,
   input logic [1:0]      b_resp,
   input logic            proto_err
);
   a_r2_one_open: assert property (@(posedge clk) disable iff (!rst_sync_n)
      aw_ready |-> !(w_ready || b_valid));

   a_r3_data_after_addr: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(w_ready) |-> $past(aw_valid && aw_ready));

   a_r6_resp_after_beat: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(b_valid) |-> $past(w_valid && w_ready));

   a_r6_resp_okay: assert property (@(posedge clk) disable iff (!rst_sync_n)
      b_valid |-> (b_resp == 2'b00));

   a_r7_resp_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (b_valid && !b_ready) |=> (b_valid && $stable(b_id) && $stable(b_resp)));

   a_r7_resp_drop: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (b_valid && b_ready) |=> !b_valid);

   a_r8_err_on_beat: assert property (@(posedge clk) disable iff (!rst_sync_n)
      proto_err |-> $past(w_valid && w_ready));
endmodule

bind wrs_wr_slave wrs_chk #(.ID_W(ID_W)) u_wrs_chk (
   .clk       (clk),
   .rst_sync_n(rst_sync_n),
   .aw_valid  (aw_valid),
   .aw_ready  (aw_ready),
   .w_valid   (w_valid),
   .w_ready   (w_ready),
   .b_valid   (b_valid),
   .b_ready   (b_ready),
   .b_id      (b_id),
   .b_resp    (b_resp),
   .proto_err (proto_err)
);

// File: tb/wrs_wr_slave_test.sv
`timescale 1ns/1ps
module wrs_wr_slave_test;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        aw_valid = 1'b0, aw_ready;
   logic [3:0]  aw_id = '0;
   logic [11:0] aw_addr = '0;
   logic [7:0]  aw_len = '0;
   logic [2:0]  aw_size = 3'd2;
   logic [1:0]  aw_burst = 2'b01;
   logic        aw_lock = 1'b0;
   logic [3:0]  aw_cache = '0;
   logic [2:0]  aw_prot = '0;
   logic [3:0]  aw_qos = '0;
   logic        w_valid = 1'b0, w_ready;
   logic [31:0] w_data = '0;
   logic [3:0]  w_strb = '0;
   logic        w_last = 1'b0;
   logic        b_valid, b_ready = 1'b0;
   logic [3:0]  b_id;
   logic [1:0]  b_resp;
   logic        proto_err;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_data;

   int checks = 0, errors = 0;
   bit cmp_en = 1'b0, done = 1'b0;

   // reference model state
   int          m_ph = 0, m_cnt = 0, m_len = 0, m_idx = 0;
   bit          m_fixed = 1'b0, m_err = 1'b0;
   logic [3:0]  m_id = '0;
   logic [31:0] mmem [DEPTH];

   always #2 clk = ~clk;

   wrs_wr_slave uut (.*);

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!cmp_en) begin
         m_ph = 0;
         m_err = 1'b0;
      end else begin
         m_err = 1'b0;
         case (m_ph)
            0: if (aw_valid) begin
               m_ph = 1; m_cnt = 0; m_len = int'(aw_len);
               m_idx = int'(aw_addr[5:2]); m_fixed = (aw_burst == 2'b00); m_id = aw_id;
            end
            1: if (w_valid) begin
               for (int n = 0; n < 4; n++)
                  if (w_strb[n]) mmem[m_idx][8*n +: 8] = w_data[8*n +: 8];
               m_err = (w_last != (m_cnt == m_len));
               if (m_cnt == m_len) m_ph = 2;
               else begin
                  m_cnt++;
                  if (!m_fixed) m_idx = (m_idx + 1) % DEPTH;
               end
            end
            default: if (b_ready) m_ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(aw_ready, m_ph == 0, "R2 aw_ready");
         chk(w_ready, m_ph == 1, "R3 w_ready");
         chk(b_valid, m_ph == 2, "R6/R7 b_valid");
         if (m_ph == 2) begin
            chk(b_id, m_id, "R6 b_id");
            chk(b_resp, 2'b00, "R6 b_resp");
         end
         chk(proto_err, m_err, "R8 proto_err");
      end
   end

   task automatic chk_mem(input string tag);
      for (int w = 0; w < DEPTH; w++) begin
         rd_idx = w[3:0];
         #1;
         chk(rd_data, mmem[w], tag);
      end
   endtask

   // smode: 0 all lanes, 1 alternating lanes, 2 no lanes
   task automatic burst(input logic [3:0] id, input logic [11:0] addr, input int len,
                        input logic [1:0] btype, input int lastpos, input int smode,
                        input int gap, input int bdelay);
      @(negedge clk);
      aw_id = id; aw_addr = addr; aw_len = len[7:0]; aw_burst = btype;
      aw_cache = id; aw_prot = id[2:0]; aw_lock = id[0]; aw_qos = ~id;
      aw_size = id[2:0];
      aw_valid = 1'b1;
      while (!aw_ready) @(negedge clk);
      @(negedge clk);
      aw_valid = 1'b0;
      for (int b = 0; b <= len; b++) begin
         repeat (gap) @(negedge clk);
         w_data = {id, 4'h5, b[7:0], 16'hC0DE ^ {addr[7:0], b[7:0]}};
         w_strb = (smode == 0) ? 4'hF : (smode == 1) ? (b[0] ? 4'b1010 : 4'b0101) : 4'h0;
         w_last = (b == lastpos);
         w_valid = 1'b1;
         while (!w_ready) @(negedge clk);
         @(negedge clk);
         w_valid = 1'b0;
         w_last = 1'b0;
      end
      repeat (bdelay) @(negedge clk);
      b_ready = 1'b1;
      while (!b_valid) @(negedge clk);
      @(negedge clk);
      b_ready = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      for (int w = 0; w < DEPTH; w++) mmem[w] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state, all ready/valid low and store cleared
      chk(aw_ready, 1'b0, "R1 aw_ready in reset");
      chk(w_ready, 1'b0, "R1 w_ready in reset");
      chk(b_valid, 1'b0, "R1 b_valid in reset");
      chk(proto_err, 1'b0, "R1 proto_err in reset");
      chk_mem("R1 store cleared");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(aw_ready, 1'b1, "R1 aw_ready after release");
      cmp_en = 1'b1;
      @(negedge clk);

      burst(4'h1, 12'h000, 3, 2'b01, 3, 0, 0, 0);   // R5 incrementing, full strobes
      chk_mem("R4/R5 incr burst");
      burst(4'h2, 12'h010, 1, 2'b01, 1, 1, 1, 3);   // R4 partial strobes, R7 held response
      chk_mem("R4 partial strobes");
      burst(4'h3, 12'h020, 2, 2'b01, 2, 2, 0, 0);   // R4 zero-strobe beats still counted
      chk_mem("R4 zero strobes unchanged");
      burst(4'h4, 12'h030, 3, 2'b00, 3, 0, 0, 1);   // R5 fixed burst, one word
      chk_mem("R5 fixed burst");
      burst(4'h5, 12'h038, 3, 2'b01, 3, 0, 2, 0);   // R5 index wraps modulo depth
      chk_mem("R5 index wrap");
      burst(4'h6, 12'h020, 3, 2'b01, 1, 0, 0, 0);   // R8 early last, burst still full length
      chk_mem("R8 early last full burst");
      burst(4'h7, 12'h024, 0, 2'b01, -1, 0, 0, 2);  // R8 missing last on single beat
      chk_mem("R8 missing last");
      burst(4'hE, 12'h03C, 0, 2'b10, 0, 1, 0, 5);   // R9 odd attributes ignored
      chk_mem("R9 attributes ignored");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule